// File: doc/BRIEF.md
# Control-Bit Preset ALU

This block is a purely combinational two's-complement arithmetic and logic unit for two operands of width `W` (3 by default). No opcode is decoded. Six independent control bits shape the operation as a fixed chain of stages, and the same hardware yields addition, constants, negation-style results and masked logic. Each operand can first be cleared and then bit-inverted. A selector then picks either the ripple-carry sum or the bitwise AND of the two conditioned operands. A last stage can invert the chosen value.

Beside the result, the block brings out the carry leaving each bit position of the ripple adder, the highest of which is the carry-out. It also gives a flag for an all-zero result and a flag that copies the result's sign bit. A datapath can use these to build compare and branch decisions without extra logic. The adder always runs, whichever value the selector picks, so the carry outputs always describe the sum of the conditioned operands.

Top module: `alu_preset`

## Requirements
- R1: With `clr_a`=1, operand A is treated as all zeros before any inversion; with `clr_a`=0 it passes unchanged.
- R2: With `inv_a`=1, the possibly cleared operand A is bit-inverted; the clear is applied first, so `clr_a`=1 and `inv_a`=1 give all ones.
- R3: `clr_b` and `inv_b` act on operand B exactly as `clr_a` and `inv_a` act on A, in the same order.
- R4: With `sel_sum`=1, the pre-inversion value is the sum of the conditioned operands with carry-in 0, truncated to `W` bits.
- R5: With `sel_sum`=0, the pre-inversion value is the bitwise AND of the conditioned operands.
- R6: With `inv_out`=1, `result` is the bitwise inverse of the value picked by `sel_sum`; with `inv_out`=0 it is that value unchanged.
- R7: `zero_flag` is 1 exactly when all `W` bits of `result` are 0.
- R8: `neg_flag` equals bit `W-1` of `result`.
- R9: `carries[i]` is the carry out of bit position `i` of the adder on the conditioned operands (carry-in 0), so `carries[W-1]` is the carry-out; it does not depend on `sel_sum` or `inv_out`.
- R10: The setting `clr_a`=1, `inv_a`=1, `clr_b`=1, `inv_b`=0, `sel_sum`=1, `inv_out`=0 gives `result` all ones (-1) with `neg_flag`=1 and `zero_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | Operand A, two's complement |
| op_b | input | W | Operand B, two's complement |
| clr_a | input | 1 | Force operand A to zero |
| inv_a | input | 1 | Invert operand A after the clear stage |
| clr_b | input | 1 | Force operand B to zero |
| inv_b | input | 1 | Invert operand B after the clear stage |
| sel_sum | input | 1 | 1 picks the sum, 0 picks the bitwise AND |
| inv_out | input | 1 | Invert the picked value |
| result | output | W | Final result |
| carries | output | W | Carry out of each adder bit; top bit is the carry-out |
| zero_flag | output | 1 | Result is all zeros |
| neg_flag | output | 1 | Sign bit of the result |

## Verification
The block holds no state, so a wrong internal value shows at the ports within the same evaluation: a misrouted clear or invert stage changes `result` and the flags for the very input vector that uses it. A broken link in the carry chain shows in `carries` for operand pairs whose lower bits carry into the faulty position, even when `sel_sum` hides the sum. So every control combination is driven with every operand pair at the default width, and with a spread of operand pairs at width 8. Each output is compared with arithmetic done in the bench.

// File: rtl/alu_preset.sv
module alu_preset #(
  parameter int W = 3
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_sum,
  input  logic         inv_out,
  output logic [W-1:0] result,
  output logic [W-1:0] carries,
  output logic         zero_flag,
  output logic         neg_flag
);

  logic [W-1:0] a_clr, a_cond, b_clr, b_cond;
  logic [W-1:0] sum, conj, picked;
  logic [W:0]   chain;

  assign a_clr  = clr_a ? '0 : op_a;
  assign a_cond = inv_a ? ~a_clr : a_clr;
  assign b_clr  = clr_b ? '0 : op_b;
  assign b_cond = inv_b ? ~b_clr : b_clr;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    logic half;
    assign half       = a_cond[i] ^ b_cond[i];
    assign sum[i]     = half ^ chain[i];
    assign chain[i+1] = (a_cond[i] & b_cond[i]) | (chain[i] & half);
  end

  assign conj    = a_cond & b_cond;
  assign picked  = sel_sum ? sum : conj;
  assign result  = inv_out ? ~picked : picked;
  assign carries = chain[W:1];

  assign zero_flag = ~|result;
  assign neg_flag  = result[W-1];

endmodule

// File: rtl/alu_preset_chk.sv
module alu_preset_chk #(
  parameter int W = 3
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         clr_a,
  input logic         inv_a,
  input logic         clr_b,
  input logic         inv_b,
  input logic         sel_sum,
  input logic         inv_out,
  input logic [W-1:0] result,
  input logic [W-1:0] carries,
  input logic         zero_flag,
  input logic         neg_flag
);

  logic         plain;
  logic [W:0]   wide;
  logic [W-1:0] add_ref;

  assign plain   = !clr_a && !inv_a && !clr_b && !inv_b;
  assign wide    = {1'b0, op_a} + {1'b0, op_b};
  assign add_ref = wide[W-1:0];

  always_comb begin
    assert_zero_flag_R7: assert (zero_flag == (result == '0));
    assert_neg_flag_R8: assert (neg_flag == result[W-1]);
    if (plain && sel_sum && !inv_out)
      assert_plain_sum_R4: assert (result == add_ref);
    if (plain && sel_sum && inv_out)
      assert_inverted_sum_R6: assert (result == ~add_ref);
    if (plain && !sel_sum && !inv_out)
      assert_plain_and_R5: assert (result == (op_a & op_b));
    if (plain)
      assert_carry_out_R9: assert (carries[W-1] == wide[W]);
    if (clr_a && inv_a && clr_b && !inv_b && sel_sum && !inv_out)
      assert_minus_one_R10: assert (result == '1);
  end

endmodule

bind alu_preset alu_preset_chk #(.W(W)) u_chk (
  .op_a(op_a), .op_b(op_b), .clr_a(clr_a), .inv_a(inv_a),
  .clr_b(clr_b), .inv_b(inv_b), .sel_sum(sel_sum), .inv_out(inv_out),
  .result(result), .carries(carries), .zero_flag(zero_flag), .neg_flag(neg_flag)
);

// File: tb/tb_alu_preset.sv
`timescale 1ns/1ps
module tb_alu_preset;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] ctl;
  logic [2:0] x3, y3;
  logic [7:0] x8, y8;
  logic [2:0] r3, c3;
  logic [7:0] r8, c8;
  logic z3, n3, z8, n8;

  alu_preset #(.W(3)) dut (
    .op_a(x3), .op_b(y3), .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]),
    .inv_b(ctl[2]), .sel_sum(ctl[1]), .inv_out(ctl[0]),
    .result(r3), .carries(c3), .zero_flag(z3), .neg_flag(n3)
  );

  alu_preset #(.W(8)) dut8 (
    .op_a(x8), .op_b(y8), .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]),
    .inv_b(ctl[2]), .sel_sum(ctl[1]), .inv_out(ctl[0]),
    .result(r8), .carries(c8), .zero_flag(z8), .neg_flag(n8)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s ctl=%b act=%0d exp=%0d", tag, what, ctl, act, exp);
    end
  endtask

  // expected values from the requirements, done with integer arithmetic
  task automatic verify(int w, int x, int y, int r, int c, int z, int n);
    int mask, a, b, pv, res, car, lm;
    string tag;
    mask = (1 << w) - 1;
    a = ctl[5] ? 0 : x;                 // R1
    if (ctl[4]) a = ~a & mask;          // R2
    b = ctl[3] ? 0 : y;                 // R3
    if (ctl[2]) b = ~b & mask;
    pv = ctl[1] ? ((a + b) & mask) : (a & b);   // R4 / R5
    res = ctl[0] ? (~pv & mask) : pv;           // R6
    car = 0;
    for (int i = 0; i < w; i++) begin
      lm = (2 << i) - 1;
      car |= (((a & lm) + (b & lm)) >> (i + 1) & 1) << i;
    end
    tag = ctl[0] ? "R6" : (ctl[1] ? "R4" : "R5");
    chk(tag, "result", r, res);
    chk("R9", "carries", c, car);
    chk("R7", "zero_flag", z, (res == 0) ? 1 : 0);
    chk("R8", "neg_flag", n, (res >> (w - 1)) & 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ctl = '0; x3 = '0; y3 = '0; x8 = '0; y8 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "idle result", int'(r3), 0);
    chk("R7", "idle zero_flag", int'(z3), 1);

    // directed stage-order cases, width 3
    x3 = 3'd5; y3 = 3'd6;
    ctl = 6'b100010; #2; chk("R1", "clear A then add", int'(r3), 6);
    ctl = 6'b110000; #2; chk("R2", "clear A, invert, AND", int'(r3), 6);
    ctl = 6'b001010; #2; chk("R3", "clear B then add", int'(r3), 5);
    ctl = 6'b001100; #2; chk("R3", "clear B, invert, AND", int'(r3), 5);
    ctl = 6'b000100; #2; chk("R3", "invert B, AND", int'(r3), 5 & 1);
    ctl = 6'b111010; #2;
    chk("R10", "minus one result", int'(r3), 7);
    chk("R10", "minus one neg_flag", int'(n3), 1);
    chk("R10", "minus one zero_flag", int'(z3), 0);
    x8 = 8'd77; y8 = 8'd200; #2;
    chk("R10", "minus one result w8", int'(r8), 255);

    // exhaustive sweep at width 3
    for (int k = 0; k < 64; k++) begin
      ctl = k[5:0];
      for (int xa = 0; xa < 8; xa++) begin
        for (int yb = 0; yb < 8; yb++) begin
          x3 = xa[2:0]; y3 = yb[2:0];
          #2;
          verify(3, xa, yb, int'(r3), int'(c3), int'(z3), int'(n3));
        end
      end
    end

    // all controls, spread of operand pairs at width 8
    for (int k = 0; k < 64; k++) begin
      ctl = k[5:0];
      for (int xa = 0; xa < 256; xa += 37) begin
        for (int yb = 0; yb < 256; yb += 51) begin
          x8 = xa[7:0]; y8 = yb[7:0];
          #2;
          verify(8, xa, yb, int'(r8), int'(c8), int'(z8), int'(n8));
        end
      end
      x8 = 8'hFF; y8 = 8'h01; #2;
      verify(8, 255, 1, int'(r8), int'(c8), int'(z8), int'(n8));
      x8 = 8'h80; y8 = 8'h80; #2;
      verify(8, 128, 128, int'(r8), int'(c8), int'(z8), int'(n8));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule